// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

A bank of independent 32-bit countdown timers reached over an APB slave port. Software programs a start value per channel, sets that channel's run bit, and the counter then steps down by one every clock. When a counter has sat at zero for one clock, the channel latches a pending interrupt. It then restarts, either from its programmed start value or from all ones, depending on the channel's mode bit. The live count can be read at any time, so a free-running channel gives an increasing timestamp once its value is inverted.

Each channel has its own interrupt mask bit. A channel's pending flag is cleared when its acknowledge register is read, and a shared acknowledge register clears every channel at once. Software sees pending flags both before and after masking. Each channel drives an interrupt line from its masked flag, and one further line is the OR of all of them. The number of channels is a parameter from 1 to 8. Channel register blocks repeat every 0x14 bytes, and the shared registers start at 0xA0.

Top module: `dtmr_bank`

## Requirements
- R1: Channel n's registers sit at byte address n*0x14 plus an offset: start value (read/write) at +0x00, live count (read-only) at +0x04, control at +0x08, acknowledge at +0x0C and masked status at +0x10. Control reads back its bits [2:0] and zeros above.
- R2: Control bit 0 is run. A write that takes run from 0 to 1 loads the counter from the start-value register at that write's clock edge. A control write with run already at 1 does not reload the counter.
- R3: While run is 1, the counter drops by one on every clock, and the live-count register returns the current counter value.
- R4: A run-enabled counter that is at zero sets the channel's pending flag on the next edge. On that same edge it reloads: from the start value when control bit 1 is 1 (periodic mode, period = start value + 1 clocks), and from 0xFFFF_FFFF when bit 1 is 0 (free-running mode).
- R5: While run is 0, the counter keeps its value and no pending flag is raised.
- R6: A start-value write while the channel runs does not disturb the current count. The new value is used at the next reload.
- R7: Reading a channel's acknowledge register returns 0 and clears that channel's pending flag. Reading address 0xA4 returns 0 and clears every channel's flag.
- R8: Control bit 2 set to 1 masks the channel. The masked flag is the pending flag AND NOT the mask bit. It is read at the channel's +0x10 (bit 0) and at 0xA0 (bit n for channel n), drives irq[n], and irqAll is the OR of the masked flags.
- R9: Address 0xA8 returns the unmasked pending flags, with bit n for channel n, whatever the mask bits are.
- R10: Address 0xAC returns the VERSION parameter. Any other address, including the blocks of channels beyond NCH, reads as 0, and writes to it change nothing.
- R11: After reset, all registers, counters, pending flags and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (8) | Byte address |
| pwdata | input | DW (32) | Write data |
| prdata | output | DW (32) | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| irq | output | NCH | Per-channel masked interrupt |
| irqAll | output | 1 | OR of all channel interrupts |

## Verification
The bench builds the block with NCH = 4 and a non-default VERSION. Four channels leave the address blocks of channels 4 to 7 unmapped, so the bench can check that these addresses read as zero and ignore writes. A distinct version value shows the parameter reaching the read path. Small start values (2 to 6) put each reload, each pending-flag edge and each acknowledge clear within a handful of bus transfers, so exact counter values can be predicted cycle by cycle. The free-running wrap to all ones is also seen within a few cycles.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CH_STRIDE  = 'h14;
  localparam int OFS_START  = 'h00;
  localparam int OFS_COUNT  = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_ACK    = 'h0C;
  localparam int OFS_STAT   = 'h10;
  localparam int GLB_STAT   = 'hA0;
  localparam int GLB_ACK    = 'hA4;
  localparam int GLB_RAW    = 'hA8;
  localparam int GLB_VER    = 'hAC;

  // strobes from control to datapath, one per channel
  typedef struct packed {
    logic load;      // reload counter from start value now
    logic run;       // channel enabled
    logic periodic;  // 1: reload start value, 0: reload all ones
  } chStrobe_t;
endpackage

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
  import dtmr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [31:0] VERSION = 32'h0000_0100
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [AW-1:0]             paddr,
  input  logic [DW-1:0]             pwdata,
  output logic [DW-1:0]             prdata,
  input  logic [NCH-1:0][DW-1:0]    count,
  input  logic [NCH-1:0]            zeroHit,
  output chStrobe_t [NCH-1:0]       strobe,
  output logic [NCH-1:0][DW-1:0]    loadVal,
  output logic [NCH-1:0]            chEn,
  output logic [NCH-1:0]            chMask,
  output logic [NCH-1:0]            rawStat,
  output logic [NCH-1:0]            irq,
  output logic                      irqAll
);
  logic accWr, accRd;
  logic [NCH-1:0] selStart, selCount, selCtrl, selAck, selStat;
  logic [NCH-1:0] chPer, masked, ackClr;
  logic selGStat, selGAck, selGRaw, selGVer;

  assign accWr = psel && penable && pwrite;
  assign accRd = psel && penable && !pwrite;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      selStart[i] = (paddr == AW'(i*CH_STRIDE + OFS_START));
      selCount[i] = (paddr == AW'(i*CH_STRIDE + OFS_COUNT));
      selCtrl[i]  = (paddr == AW'(i*CH_STRIDE + OFS_CTRL));
      selAck[i]   = (paddr == AW'(i*CH_STRIDE + OFS_ACK));
      selStat[i]  = (paddr == AW'(i*CH_STRIDE + OFS_STAT));
    end
  end

  assign selGStat = (paddr == AW'(GLB_STAT));
  assign selGAck  = (paddr == AW'(GLB_ACK));
  assign selGRaw  = (paddr == AW'(GLB_RAW));
  assign selGVer  = (paddr == AW'(GLB_VER));

  assign ackClr = {NCH{accRd}} & (selAck | {NCH{selGAck}});
  assign masked = rawStat & ~chMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal <= '0;
      chEn    <= '0;
      chPer   <= '0;
      chMask  <= '0;
      rawStat <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (accWr && selStart[i]) loadVal[i] <= pwdata;
        if (accWr && selCtrl[i]) begin
          chEn[i]   <= pwdata[0];
          chPer[i]  <= pwdata[1];
          chMask[i] <= pwdata[2];
        end
        // a new expiry wins over a same-cycle acknowledge
        if (zeroHit[i])     rawStat[i] <= 1'b1;
        else if (ackClr[i]) rawStat[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      strobe[i].load     = accWr && selCtrl[i] && pwdata[0] && !chEn[i];
      strobe[i].run      = chEn[i];
      strobe[i].periodic = chPer[i];
    end
  end

  always_comb begin
    prdata = '0;
    if (accRd) begin
      for (int i = 0; i < NCH; i++) begin
        if (selStart[i]) prdata = loadVal[i];
        if (selCount[i]) prdata = count[i];
        if (selCtrl[i])  prdata = DW'({chMask[i], chPer[i], chEn[i]});
        if (selStat[i])  prdata = DW'(masked[i]);
      end
      if (selGStat) prdata = DW'(masked);
      if (selGRaw)  prdata = DW'(rawStat);
      if (selGVer)  prdata = DW'(VERSION);
    end
  end

  assign irq    = masked;
  assign irqAll = |masked;
endmodule

// File: rtl/dtmr_dp.sv
module dtmr_dp
  import dtmr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  chStrobe_t [NCH-1:0]    strobe,
  input  logic [NCH-1:0][DW-1:0] loadVal,
  output logic [NCH-1:0][DW-1:0] count,
  output logic [NCH-1:0]         zeroHit
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign zeroHit[g] = strobe[g].run && (count[g] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        count[g] <= '0;
      end else if (strobe[g].load) begin
        count[g] <= loadVal[g];
      end else if (strobe[g].run) begin
        if (count[g] == '0) count[g] <= strobe[g].periodic ? loadVal[g] : '1;
        else                count[g] <= count[g] - DW'(1);
      end
    end
  end
endmodule

// File: rtl/dtmr_bank.sv
module dtmr_bank
  import dtmr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [31:0] VERSION = 32'h0000_0100
) (
  input  logic           pclk,
  input  logic           presetn,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [DW-1:0]  pwdata,
  output logic [DW-1:0]  prdata,
  output logic           pready,
  output logic [NCH-1:0] irq,
  output logic           irqAll
);
  chStrobe_t [NCH-1:0]    strobe;
  logic [NCH-1:0][DW-1:0] loadVal;
  logic [NCH-1:0][DW-1:0] countVal;
  logic [NCH-1:0]         zeroHit, chEn, chMask, rawStat, chStart;

  assign pready = 1'b1;

  for (genvar g = 0; g < NCH; g++) begin : g_start
    assign chStart[g] = strobe[g].load;
  end

  dtmr_ctrl #(.NCH(NCH), .AW(AW), .DW(DW), .VERSION(VERSION)) ctrl_i (
    .clk(pclk), .rstN(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .count(countVal), .zeroHit(zeroHit), .strobe(strobe), .loadVal(loadVal),
    .chEn(chEn), .chMask(chMask), .rawStat(rawStat), .irq(irq), .irqAll(irqAll)
  );

  dtmr_dp #(.NCH(NCH), .DW(DW)) dp_i (
    .clk(pclk), .rstN(presetn), .strobe(strobe), .loadVal(loadVal),
    .count(countVal), .zeroHit(zeroHit)
  );
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
  import dtmr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   psel,
  input logic                   penable,
  input logic                   pwrite,
  input logic [AW-1:0]          paddr,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0]         mask,
  input logic [NCH-1:0]         start,
  input logic [NCH-1:0]         hit,
  input logic [NCH-1:0]         raw,
  input logic [NCH-1:0][DW-1:0] count,
  input logic [NCH-1:0]         irq,
  input logic                   irqAll
);
  logic gAckRd;
  assign gAckRd = psel && penable && !pwrite && (paddr == AW'(GLB_ACK));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!en[g] && !start[g]) |=> $stable(count[g]));

    p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
      (en[g] && count[g] != '0) |=> (count[g] == $past(count[g]) - DW'(1)));

    p_flag_needs_run_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(raw[g]) |-> $past(en[g]));

    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
      mask[g] |-> !irq[g]);
  end

  p_any_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqAll == (|irq));

  p_global_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    gAckRd |=> ((raw & ~$past(hit)) == '0));
endmodule

bind dtmr_bank dtmr_chk #(.NCH(NCH), .AW(AW), .DW(DW)) chk_i (
  .clk(pclk), .rstN(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .en(chEn), .mask(chMask),
  .start(chStart), .hit(zeroHit), .raw(rawStat), .count(countVal),
  .irq(irq), .irqAll(irqAll)
);

// File: tb/dtmr_bank_tb.sv
module dtmr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam logic [31:0] VER = 32'h0000_0A5C;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready;
  logic [NCH-1:0] irq;
  logic irqAll;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string tagQ[$];
  event sampleEv;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  dtmr_bank #(.NCH(NCH), .VERSION(VER)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq(irq), .irqAll(irqAll)
  );

  // monitor: compares read data in the access phase, away from the edge
  always @(sampleEv) begin
    logic [31:0] e;
    string t;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    compared++;
    if (prdata !== e) begin
      mismatched++;
      $display("FAIL %s: addr %02h got %08h expected %08h", t, paddr, prdata, e);
    end
  end

  // tasks start right after a falling edge; each transfer spans two cycles
  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic apbRead(input logic [7:0] a, input logic [31:0] e, input string t);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(t);
    #(CLK_PERIOD/4);
    ->sampleEv;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic checkIrq(input logic [NCH-1:0] e, input logic eAll, input string t);
    compared++;
    if (irq !== e || irqAll !== eAll) begin
      mismatched++;
      $display("FAIL %s: irq %b/%b expected %b/%b", t, irq, irqAll, e, eAll);
    end
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R11 reset state
    checkIrq('0, 1'b0, "R11 irq after reset");
    apbRead(8'h04, 32'h0, "R11 count after reset");
    apbRead(8'h08, 32'h0, "R11 ctrl after reset");
    apbRead(8'hA8, 32'h0, "R11 raw after reset");
    apbRead(8'h10, 32'h0, "R11 status after reset");

    // channel 0 periodic, start value 5
    apbWrite(8'h00, 32'd5);
    apbWrite(8'h08, 32'h3);                   // edge E, count = 5
    apbRead(8'h04, 32'd4, "R2 R3 count at E+2");
    apbRead(8'h04, 32'd2, "R3 count at E+4");
    apbRead(8'h04, 32'd0, "R3 count at E+6");
    apbRead(8'hA8, 32'h1, "R4 R9 flag set after zero");
    checkIrq(4'b0001, 1'b1, "R8 irq ch0 unmasked");
    apbRead(8'h0C, 32'h0, "R7 channel ack returns 0");
    apbRead(8'hA8, 32'h0, "R7 channel ack cleared flag");
    apbWrite(8'h08, 32'h0);                   // E+14, count becomes 3
    apbRead(8'hA4, 32'h0, "R7 global ack returns 0");
    apbRead(8'hA8, 32'h0, "R7 global ack cleared flag");
    apbRead(8'h04, 32'd3, "R5 count held after disable");
    repeat (20) @(negedge pclk);
    apbRead(8'h04, 32'd3, "R5 count still held");
    apbRead(8'hA8, 32'h0, "R5 no flag while disabled");
    apbRead(8'h08, 32'h0, "R1 ctrl readback");

    // restart and non-reloading rewrite
    apbWrite(8'h08, 32'h3);                   // H
    apbRead(8'h04, 32'd4, "R2 restart reloads start value");
    apbWrite(8'h08, 32'h3);                   // H+4, no reload
    apbRead(8'h04, 32'd0, "R2 rewrite with run set keeps count");
    apbWrite(8'h08, 32'h0);
    apbRead(8'hA4, 32'h0, "R7 global ack");

    // channel 1 free-running, masked, start value 3
    apbWrite(8'h14, 32'd3);
    apbWrite(8'h1C, 32'h5);                   // F
    apbRead(8'h18, 32'd2, "R3 ch1 count at F+2");
    apbRead(8'h18, 32'd0, "R3 ch1 count at F+4");
    apbRead(8'h18, 32'hFFFF_FFFE, "R4 free-running wraps to all ones");
    apbRead(8'hA8, 32'h2, "R9 raw ignores mask");
    apbRead(8'hA0, 32'h0, "R8 combined masked hides ch1");
    apbRead(8'h24, 32'h0, "R8 ch1 status masked");
    checkIrq(4'b0000, 1'b0, "R8 masked irq low");
    apbWrite(8'h1C, 32'h1);                   // unmask, run already set
    apbRead(8'hA0, 32'h2, "R8 combined masked bit 1");
    checkIrq(4'b0010, 1'b1, "R8 irq ch1 after unmask");
    apbRead(8'h24, 32'h1, "R8 ch1 status");
    apbRead(8'h20, 32'h0, "R7 ch1 ack returns 0");
    apbRead(8'hA8, 32'h0, "R7 ch1 flag cleared");
    checkIrq(4'b0000, 1'b0, "R7 irq low after ack");
    apbRead(8'h1C, 32'h1, "R1 ch1 ctrl readback");
    apbWrite(8'h1C, 32'h0);

    // channel 2 start value rewritten while running
    apbWrite(8'h28, 32'd2);
    apbWrite(8'h30, 32'h3);                   // G
    apbWrite(8'h28, 32'd6);                   // G+2, count at zero
    apbRead(8'h2C, 32'd6, "R6 new start value used at reload");
    apbRead(8'h28, 32'd6, "R1 ch2 start readback");
    apbWrite(8'h30, 32'h0);
    apbRead(8'hA4, 32'h0, "R7 global ack");
    apbRead(8'hA8, 32'h0, "R7 all flags clear");

    // unmapped space and version
    apbRead(8'hAC, VER, "R10 version");
    apbRead(8'hB0, 32'h0, "R10 unmapped reads zero");
    apbWrite(8'h50, 32'hDEAD_BEEF);           // channel 4 block, absent
    apbRead(8'h50, 32'h0, "R10 absent channel reads zero");
    apbRead(8'h00, 32'd5, "R10 write to unmapped left ch0 intact");
    apbRead(8'h3C, 32'h0, "R10 ch3 start unchanged");

    repeat (2) @(negedge pclk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule